// File: doc/BRIEF.md
# Nested-Priority Interrupt Controller

This block gathers four interrupt sources into one interrupt line to a processor. Each source is wired to a fixed request level: source 0 to level 0, source 1 to level 3, source 2 to level 4 and source 3 to level 5. Levels 1, 2, 6 and 7 exist in the priority space but are never raised. A rising edge on a source latches a pending request for its level.

Priority is static and fully nested. Level 0 is the most urgent and level 7 the least. While a level is in service, only a strictly more urgent level may drive the processor line. The processor takes the winner with an acknowledge pulse and receives its vector one cycle later.

A small write port holds two registers. The command register accepts only the specific end-of-interrupt code, which retires one in-service level. Every other command value is dropped. The mask register blocks individual levels from reaching the processor.

Top module: `nest_intc`

## Requirements
- R1: After reset all eight mask bits are 1, no level is pending or in service, `irq_out` is 0 and `vec_valid` is 0.
- R2: Sources are bound to fixed levels: `irq_src[0]`→0, `irq_src[1]`→3, `irq_src[2]`→4, `irq_src[3]`→5. The vector of level L is `VEC_BASE + L`, with `VEC_BASE` defaulting to 0x20.
- R3: A 0→1 transition on a source sets its level's pending bit at the next clock edge. A source held high does not set the bit again after it is acknowledged.
- R4: Writing with `wr_sel`=1 loads `wr_data` into the mask register. Bit n = 1 blocks level n and bit n = 0 enables it. A blocked level never drives `irq_out`, but it stays pending and is forwarded once it is unblocked.
- R5: Among pending, unmasked levels, the lowest level number wins.
- R6: While any level is in service, `irq_out` is 1 only if the winner's number is strictly lower than the lowest in-service level number.
- R7: When `inta` is 1 and `irq_out` is 1 at a clock edge, the winner moves from pending to in service, and in the next cycle `vec_valid` is 1 for one cycle with `vec` = `VEC_BASE` + winner. When `inta` is 1 and `irq_out` is 0, nothing changes and `vec_valid` stays 0.
- R8: Writing with `wr_sel`=0 and `wr_data` = 0x60 | L (that is, bits 7:3 = 01100) clears the in-service bit of level L. Less urgent pending levels then become eligible again.
- R9: A command write whose bits 7:3 differ from 01100 (for example 0x20, 0x68 or 0x0B) leaves the in-service state unchanged.
- R10: `irq_out` is a combinational function of the pending, mask and in-service state. It follows the state in the same cycle it changes and is 0 when no level is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 4 | Interrupt sources, rising-edge sensitive |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the command register, 1 selects the mask register |
| wr_data | input | 8 | Write data |
| inta | input | 1 | Acknowledge pulse from the processor |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after an accepted acknowledge |
| vec | output | 8 | Vector of the acknowledged level |

## Verification
A source edge, a mask write or an end-of-interrupt write changes the state at the next clock edge. `irq_out` follows that state combinationally, so it is due in the cycle right after the stimulus. An accepted acknowledge produces `vec_valid` and `vec` in the following cycle, and they are gone one cycle after that.

The bench drives inputs on the falling edge. A behavioural model updates on the rising edge, and the design is compared to the model at each falling edge. Directed checks are placed exactly one cycle after each stimulus, including the nested-hold, masked-hold and ignored-command cases.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LVLS  = 8;
    localparam int LVL_W = $clog2(LVLS);
    localparam int NSRC  = 4;
    localparam logic [4:0] SEOI_OP = 5'b01100;

    typedef logic [LVLS-1:0] lvl_vec_t;

    typedef enum logic {SEL_CMD = 1'b0, SEL_MASK = 1'b1} reg_sel_e;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    function automatic logic [LVL_W-1:0] src_level(input int idx);
        case (idx)
            0:       return LVL_W'(0);
            1:       return LVL_W'(3);
            2:       return LVL_W'(4);
            default: return LVL_W'(5);
        endcase
    endfunction

    function automatic pick_t first_set(input lvl_vec_t v);
        pick_t p;
        p = '0;
        for (int i = LVLS - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.lvl = LVL_W'(i);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/intc_req_latch.sv
module intc_req_latch
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    input  lvl_vec_t        clr,
    output lvl_vec_t        pend
);
    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] rise;
    lvl_vec_t        set_v;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) src_q[g] <= 1'b0;
            else     src_q[g] <= src[g];
        end
        assign rise[g] = src[g] & ~src_q[g];

        p_edge_sets_r3: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> pend[src_level(g)]);
    end

    always_comb begin
        set_v = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (rise[i]) set_v[src_level(i)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | set_v;
    end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  reg_sel_e   wr_sel,
    input  logic [7:0] wr_data,
    input  lvl_vec_t   grant,
    output lvl_vec_t   mask,
    output lvl_vec_t   insvc
);
    logic     seoi_hit;
    lvl_vec_t retire;

    assign seoi_hit = wr_en && (wr_sel == SEL_CMD) && (wr_data[7:3] == SEOI_OP);

    always_comb begin
        retire = '0;
        if (seoi_hit) retire[wr_data[LVL_W-1:0]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask  <= '1;
            insvc <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_MASK) mask <= wr_data[LVLS-1:0];
            insvc <= (insvc & ~retire) | grant;
        end
    end

    p_mask_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (mask == '1 && insvc == '0));

    p_eoi_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (seoi_hit && grant == '0) |=> !insvc[$past(wr_data[LVL_W-1:0])]);

    p_bad_cmd_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CMD && wr_data[7:3] != SEOI_OP && grant == '0)
        |=> $stable(insvc));
endmodule

// File: rtl/intc_resolve.sv
module intc_resolve
    import intc_pkg::*;
(
    input  lvl_vec_t         pend,
    input  lvl_vec_t         mask,
    input  lvl_vec_t         insvc,
    output logic             req,
    output logic [LVL_W-1:0] win
);
    pick_t cand;
    pick_t busy;

    always_comb begin
        cand = first_set(pend & ~mask);
        busy = first_set(insvc);
        win  = cand.lvl;
        req  = cand.hit && (!busy.hit || cand.lvl < busy.lvl);
    end
endmodule

// File: rtl/nest_intc.sv
module nest_intc
    import intc_pkg::*;
#(
    parameter logic [7:0] VEC_BASE = 8'h20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_src,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [7:0]      wr_data,
    input  logic            inta,
    output logic            irq_out,
    output logic            vec_valid,
    output logic [7:0]      vec
);
    lvl_vec_t         pend, mask, insvc, grant;
    logic [LVL_W-1:0] win;
    logic [LVL_W-1:0] vidx;
    logic             take;

    assign take = inta && irq_out;

    always_comb begin
        grant = '0;
        if (take) grant[win] = 1'b1;
    end

    intc_req_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .src  (irq_src),
        .clr  (grant),
        .pend (pend)
    );

    intc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (reg_sel_e'(wr_sel)),
        .wr_data (wr_data),
        .grant   (grant),
        .mask    (mask),
        .insvc   (insvc)
    );

    intc_resolve u_res (
        .pend  (pend),
        .mask  (mask),
        .insvc (insvc),
        .req   (irq_out),
        .win   (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec       <= '0;
        end else begin
            vec_valid <= take;
            if (take) vec <= VEC_BASE + 8'(win);
        end
    end

    assign vidx = LVL_W'(vec - VEC_BASE);

    p_ack_vec_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> (vec_valid && insvc[vidx] && !pend[vidx]));

    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        !take |=> !vec_valid);

    p_one_grant_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(insvc & ~$past(insvc)) <= 1);

    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (!mask[win] && pend[win]));

    p_nested_r6: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((insvc & ((lvl_vec_t'(1) << win) | ((lvl_vec_t'(1) << win) - 1'b1))) == '0));

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_out && !vec_valid && pend == '0));
endmodule

// File: tb/tb_nest_intc.sv
module tb_nest_intc;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] irq_src;
    logic       wr_en;
    logic       wr_sel;
    logic [7:0] wr_data;
    logic       inta;
    logic       irq_out;
    logic       vec_valid;
    logic [7:0] vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    nest_intc dut (
        .clk(clk), .rst(rst), .irq_src(irq_src), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .inta(inta), .irq_out(irq_out), .vec_valid(vec_valid), .vec(vec)
    );

    // behavioural reference model
    int m_pend[8];
    int m_mask[8];
    int m_busy[8];
    int m_prev[4];
    int m_vv;
    int m_vec;
    int lvl_of[4] = '{0, 3, 4, 5};

    function automatic int m_win();
        for (int i = 0; i < 8; i++) if (m_pend[i] != 0 && m_mask[i] == 0) return i;
        return 8;
    endfunction

    function automatic int m_top();
        for (int i = 0; i < 8; i++) if (m_busy[i] != 0) return i;
        return 8;
    endfunction

    function automatic int m_out();
        return (m_win() < 8 && m_win() < m_top()) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_mask[i] = 1; m_busy[i] = 0; end
            for (int i = 0; i < 4; i++) m_prev[i] = 0;
            m_vv = 0; m_vec = 0;
        end else begin
            int w;
            int o;
            w = m_win();
            o = m_out();
            if (wr_en && !wr_sel && wr_data[7:3] == 5'b01100) m_busy[wr_data[2:0]] = 0;
            if (wr_en && wr_sel) for (int i = 0; i < 8; i++) m_mask[i] = wr_data[i];
            m_vv = 0;
            if (inta && o != 0) begin
                m_busy[w] = 1; m_pend[w] = 0; m_vv = 1; m_vec = 32 + w;
            end
            for (int i = 0; i < 4; i++) begin
                if (irq_src[i] && m_prev[i] == 0) m_pend[lvl_of[i]] = 1;
                m_prev[i] = irq_src[i];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R10 irq_out vs model", int'(irq_out), m_out());
            chk("R7 vec_valid vs model", int'(vec_valid), m_vv);
            if (m_vv != 0) chk("R2 vec vs model", int'(vec), m_vec);
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic ack();
        inta = 1;
        tick();
        inta = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; irq_src = 0; wr_en = 0; wr_sel = 0; wr_data = 0; inta = 0;
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R1 irq_out after reset", int'(irq_out), 0);
        chk("R1 vec_valid after reset", int'(vec_valid), 0);

        irq_src[0] = 1; tick();
        chk("R4 masked by reset mask", int'(irq_out), 0);
        wr(1, 8'h00);
        chk("R4 forwarded after unmask", int'(irq_out), 1);
        ack();
        chk("R7 vec_valid after ack", int'(vec_valid), 1);
        chk("R2 vector of level 0", int'(vec), 8'h20);
        chk("R7 pending cleared", int'(irq_out), 0);
        tick();
        chk("R7 vec_valid one cycle", int'(vec_valid), 0);
        chk("R3 held source no re-latch", int'(irq_out), 0);

        irq_src[3] = 1; tick();
        chk("R6 level 5 held under level 0", int'(irq_out), 0);
        wr(0, 8'h60);
        chk("R8 eoi releases level 5", int'(irq_out), 1);
        ack();
        chk("R2 vector of level 5", int'(vec), 8'h25);

        irq_src[1] = 1; tick();
        chk("R6 level 3 preempts level 5", int'(irq_out), 1);
        ack();
        chk("R2 vector of level 3", int'(vec), 8'h23);

        irq_src[2] = 1; tick();
        chk("R6 level 4 held under level 3", int'(irq_out), 0);
        wr(0, 8'h20); wr(0, 8'h68); wr(0, 8'h0B);
        chk("R9 bad commands ignored", int'(irq_out), 0);
        wr(0, 8'h63);
        chk("R8 eoi level 3 frees level 4", int'(irq_out), 1);
        ack();
        chk("R2 vector of level 4", int'(vec), 8'h24);

        inta = 1; tick(); inta = 0;
        chk("R7 ack with idle line", int'(vec_valid), 0);

        wr(0, 8'h64); wr(0, 8'h65);
        irq_src = 4'h0; tick();
        wr(1, 8'h01);
        irq_src = 4'hF; tick();
        chk("R5 request with level 0 masked", int'(irq_out), 1);
        ack();
        chk("R5 level 3 wins over 4 and 5", int'(vec), 8'h23);
        wr(0, 8'h63);
        wr(1, 8'h00);
        chk("R4 masked level 0 still pending", int'(irq_out), 1);
        ack();
        chk("R4 level 0 forwarded", int'(vec), 8'h20);
        wr(0, 8'h60);
        ack();
        chk("R5 level 4 next", int'(vec), 8'h24);
        wr(0, 8'h64);
        ack();
        chk("R5 level 5 last", int'(vec), 8'h25);
        wr(0, 8'h65);
        chk("R10 line low with nothing eligible", int'(irq_out), 0);
        repeat (3) tick();
        finish_run();
    end
endmodule